// File: doc/BRIEF.md
# Thermometer-to-Binary Encoder with Gray Intermediate Stage

This block turns the thermometer word from a bank of flash-converter comparators into a binary sample code. The thermometer word is first reduced straight to a Gray code by small AND-NOT/OR gates. The design ensures that every thermometer bit reaches exactly one Gray bit. A comparator output that has not settled therefore enters the result through one gate only. Different gates cannot read it in conflicting ways, so the result stays close to the true code. A comparator that fires wrongly away from the transition also disturbs only one Gray bit.

The Gray code is registered. A second pipeline stage folds it into binary by running an XOR chain from the most significant bit downward, and registers the result. A valid flag travels beside the data through both registers. Both registers load only when their stage's valid bit is set, so the output holds its last code while no new samples arrive. The width is set by `NBITS`, and the thermometer word has 2^NBITS-1 bits. The default is 3 output bits from 7 thermometer bits. Reset is synchronous and active low.

Thermometer position p (1-based) is carried on `therm_in[p-1]`.

Top module: `therm_gray_encoder`

## Requirements
- R1: Gray bit j (1-based, s = 2^(j-1)) is the OR over m >= 0 of (T[s(4m+1)] AND NOT T[s(4m+3)]), with positions beyond 2^NBITS-1 read as 0. For the default width this gives G1 = T1&~T3 | T5&~T7, G2 = T2&~T6 and G3 = T4. The top output bit therefore equals thermometer position 2^(NBITS-1) of the same sample.
- R2: When a sample is a valid thermometer code holding k ones in positions 1..k, `bin_out` equals k. This holds for every k from 0 to 2^NBITS-1.
- R3: The result of a sample taken at a rising edge with `in_valid` high appears after the second rising edge. `out_valid` equals `in_valid` delayed by exactly two edges.
- R4: While `rst_n` is low at a rising edge, both registers clear: `bin_out` reads 0 and `out_valid` reads 0.
- R5: If positions 1..k are ones and only position k+1 is uncertain (either level), the output is k or k+1 and never any other code.
- R6: Flipping any single thermometer bit at position p relative to a valid code does one of two things to the binary output. Either it leaves the output unchanged, or it changes the output by XOR with 2^(t+1)-1, where t is the number of trailing zeros of p. This is a single-bit sparkle.
- R7: While `in_valid` is low, the thermometer input is ignored. `bin_out` keeps its last value and changes only on an edge where `out_valid` becomes or stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| therm_in | input | 2^NBITS-1 | Comparator word, bit p-1 is position p |
| in_valid | input | 1 | Qualifies `therm_in` at this edge |
| bin_out | output | NBITS | Binary sample code |
| out_valid | output | 1 | Marks `bin_out` as freshly loaded |

## Verification
The code-value assertion only claims a count result when the input two edges earlier was a well-formed thermometer word. The assumption on the input is therefore that only such words carry an exact numeric meaning. Sparkle and uncertain-bit patterns are judged separately by the bench, against neighbour and XOR-mask rules. The delay and hold properties assume nothing about `therm_in`. They wait until two edges have passed since reset, so every sampled history lies after reset. The stimulus changes inputs only on falling edges and pulses `in_valid` for one edge per sample. Every pattern is therefore sampled exactly once.

// File: rtl/therm_enc_pkg.sv
package therm_enc_pkg;

    localparam int MAX_THERM = 64;

    // True when the word has the form 0..01..1 (including all zeros).
    function automatic logic is_thermometer(input logic [MAX_THERM-1:0] word);
        logic [MAX_THERM-1:0] nxt;
        nxt = word + {{(MAX_THERM-1){1'b0}}, 1'b1};
        return (word & nxt) == '0;
    endfunction

endpackage

// File: rtl/therm_to_gray.sv
module therm_to_gray #(
    parameter int NBITS = 3,
    localparam int NTHERM = (1 << NBITS) - 1
) (
    input  logic [NTHERM-1:0] therm,
    output logic [NBITS-1:0]  gray
);

    // Each thermometer position p = s*odd feeds only the Gray bit whose
    // step s is the largest power of two dividing p.
    always_comb begin
        gray = '0;
        for (int j = 0; j < NBITS; j++) begin
            for (int m = 0; m < NTHERM; m++) begin
                int  p_on;
                int  p_off;
                logic on_bit;
                logic off_bit;
                p_on    = (1 << j) * (4 * m + 1);
                p_off   = (1 << j) * (4 * m + 3);
                on_bit  = 1'b0;
                off_bit = 1'b0;
                if (p_on <= NTHERM) on_bit = therm[p_on-1];
                if (p_off <= NTHERM) off_bit = therm[p_off-1];
                gray[j] = gray[j] | (on_bit & ~off_bit);
            end
        end
    end

endmodule

// File: rtl/gray_capture.sv
module gray_capture #(
    parameter int NBITS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] gray_d,
    input  logic             load,
    output logic [NBITS-1:0] gray_q,
    output logic             gray_vld
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gray_q   <= '0;
            gray_vld <= 1'b0;
        end else begin
            gray_vld <= load;
            if (load) gray_q <= gray_d;
        end
    end

endmodule

// File: rtl/gray_to_bin_stage.sv
module gray_to_bin_stage #(
    parameter int NBITS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] gray,
    input  logic             load,
    output logic [NBITS-1:0] bin_q,
    output logic             bin_vld
);

    logic [NBITS-1:0] bin_d;

    assign bin_d[NBITS-1] = gray[NBITS-1];

    generate
        for (genvar j = NBITS - 2; j >= 0; j--) begin : g_chain
            assign bin_d[j] = bin_d[j+1] ^ gray[j];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bin_q   <= '0;
            bin_vld <= 1'b0;
        end else begin
            bin_vld <= load;
            if (load) bin_q <= bin_d;
        end
    end

endmodule

// File: rtl/therm_gray_encoder.sv
module therm_gray_encoder #(
    parameter int NBITS = 3,
    localparam int NTHERM = (1 << NBITS) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NTHERM-1:0] therm_in,
    input  logic              in_valid,
    output logic [NBITS-1:0]  bin_out,
    output logic              out_valid
);

    logic [NBITS-1:0] gray_comb;
    logic [NBITS-1:0] gray_reg;
    logic             gray_vld;

    therm_to_gray #(.NBITS(NBITS)) u_t2g (
        .therm (therm_in),
        .gray  (gray_comb)
    );

    gray_capture #(.NBITS(NBITS)) u_gcap (
        .clk      (clk),
        .rst_n    (rst_n),
        .gray_d   (gray_comb),
        .load     (in_valid),
        .gray_q   (gray_reg),
        .gray_vld (gray_vld)
    );

    gray_to_bin_stage #(.NBITS(NBITS)) u_g2b (
        .clk     (clk),
        .rst_n   (rst_n),
        .gray    (gray_reg),
        .load    (gray_vld),
        .bin_q   (bin_out),
        .bin_vld (out_valid)
    );

endmodule

// File: rtl/therm_gray_encoder_chk.sv
module therm_gray_encoder_chk #(
    parameter int NBITS = 3,
    localparam int NTHERM = (1 << NBITS) - 1,
    localparam int MIDPOS = (1 << (NBITS - 1)) - 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NTHERM-1:0] therm_in,
    input logic              in_valid,
    input logic [NBITS-1:0]  bin_out,
    input logic              out_valid
);
    import therm_enc_pkg::*;

    logic [1:0] since_rst;
    logic       hist_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) since_rst <= '0;
        else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end
    assign hist_ok = (since_rst == 2'd2);

    assert_valid_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hist_ok |-> (out_valid == $past(in_valid, 2)));

    assert_count_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && $past(in_valid, 2)
         && is_thermometer(MAX_THERM'($past(therm_in, 2))))
        |-> (int'(bin_out) == $countones($past(therm_in, 2))));

    assert_top_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && $past(in_valid, 2))
        |-> (bin_out[NBITS-1] == $past(therm_in[MIDPOS], 2)));

    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(bin_out));

endmodule

bind therm_gray_encoder therm_gray_encoder_chk #(.NBITS(NBITS)) u_chk (.*);

// File: tb/therm_gray_encoder_bench.sv
module therm_gray_encoder_bench;
    localparam int NB = 3;
    localparam int NT = (1 << NB) - 1;
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NT-1:0] therm_in = '0;
    logic          in_valid = 1'b0;
    logic [NB-1:0] bin_out;
    logic          out_valid;

    int n_cmp = 0;
    int n_bad = 0;

    therm_gray_encoder #(.NBITS(NB)) u_therm_gray_encoder (
        .clk(clk), .rst_n(rst_n), .therm_in(therm_in), .in_valid(in_valid),
        .bin_out(bin_out), .out_valid(out_valid)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [NT-1:0] ones(input int k);
        logic [NT-1:0] w = '0;
        for (int i = 0; i < k; i++) w[i] = 1'b1;
        return w;
    endfunction

    // Drive one sample for one edge, return the result two edges later.
    task automatic encode(input logic [NT-1:0] w, output int res);
        @(negedge clk);
        therm_in = w;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        therm_in = ~w;
        @(negedge clk);
        check("R3 out_valid after two edges", int'(out_valid), 1);
        res = int'(bin_out);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R4 bin_out in reset", int'(bin_out), 0);
        check("R4 out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_counts();
        int r;
        for (int k = 0; k <= NT; k++) begin
            encode(ones(k), r);
            check($sformatf("R2 count k=%0d", k), r, k);
        end
        for (int k = NT; k >= 0; k--) begin
            encode(ones(k), r);
            check($sformatf("R2 descending k=%0d", k), r, k);
            check("R1 top bit follows middle position", (r >> (NB - 1)) & 1,
                  (k >= (1 << (NB - 1))) ? 1 : 0);
        end
    endtask

    task automatic t_latency();
        @(negedge clk);
        therm_in = ones(5);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R3 not yet valid after one edge", int'(out_valid), 0);
        @(negedge clk);
        check("R3 valid after two edges", int'(out_valid), 1);
        check("R3 value after two edges", int'(bin_out), 5);
        @(negedge clk);
        check("R3 valid drops after one cycle", int'(out_valid), 0);
    endtask

    task automatic t_uncertain();
        int r;
        for (int k = 0; k < NT; k++) begin
            logic [NT-1:0] w;
            w = ones(k);
            w[k] = 1'b1;
            encode(w, r);
            check($sformatf("R5 neighbour k=%0d", k),
                  int'(r == k || r == k + 1), 1);
        end
    endtask

    task automatic t_sparkle();
        int base, got, tz, mask;
        for (int k = 0; k <= NT; k += 3) begin
            encode(ones(k), base);
            for (int p = 1; p <= NT; p++) begin
                logic [NT-1:0] w;
                w = ones(k);
                w[p-1] = ~w[p-1];
                encode(w, got);
                tz = 0;
                while (((p >> tz) & 1) == 0) tz++;
                mask = (1 << (tz + 1)) - 1;
                check($sformatf("R6 flip k=%0d p=%0d", k, p),
                      int'(got == base || (got ^ base) == mask), 1);
            end
        end
    endtask

    task automatic t_hold();
        int r;
        encode(ones(6), r);
        @(negedge clk);
        therm_in = ones(1);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        check("R7 output held while idle", int'(bin_out), 6);
        check("R7 no valid while idle", int'(out_valid), 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_counts();
                t_latency();
                t_uncertain();
                t_sparkle();
                t_hold();
                t_reset();
            end
            begin
                repeat (20000) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog actual=expired expected=done");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule